// File: doc/BRIEF.md
# Line-Buffered Image Blend Engine

The engine mixes two pictures held in a shared word-addressed memory and writes the blended picture into a third region. It works one row at a time. For a row it first fetches the source pixels into one on-chip line store, then fetches the destination pixels into a second line store, and only then streams both stores through a per-channel alpha mixer while it writes the results back. Rows sit at a fixed pitch of 640 words, whatever width is programmed. Every row is cut into bursts of at most 32 beats, and the last burst is shortened to whatever pixels remain.

Software sets the mix factor, the width, the height and three base word addresses, then pulses `start`. `busy` stays high while the engine runs. `done` rises when the last row has been written and stays high until the next accepted start. Reads use a request channel (address, beat count) and a separate return channel with a last-beat flag. Several read bursts may be in flight at once. Writes use a request channel followed by a data channel.

The controller is a state machine with six states:
- `ST_IDLE` goes to `ST_SRC_RD` on a start with non-zero size.
- `ST_SRC_RD` goes to `ST_DST_RD` once every source beat has arrived and nothing is outstanding.
- `ST_DST_RD` goes to `ST_WR_REQ` under the same condition for destination beats.
- `ST_WR_REQ` goes to `ST_WR_DATA` when the write request is accepted.
- `ST_WR_DATA` returns to `ST_WR_REQ` after the last beat of a burst that does not end the row, or goes to `ST_ROW_END` after the final beat of the row.
- `ST_ROW_END` goes to `ST_SRC_RD` for the next row, or to `ST_IDLE` after the last row.

Top module: `img_blend_engine`

## Requirements
- R1: Each written pixel has bits [7:0], [15:8] and [23:16] equal to (a·s + (255−a)·d)/255, truncated. Here a is the latched mix factor, s is the source channel and d is the destination channel. Bits [31:24] are zero.
- R2: The pixel at column x of row y is read from src_base + y·640 + x and from dsti_base + y·640 + x, and it is written to dsto_base + y·640 + x. All of these are word addresses.
- R3: Within a row, every source beat is received before the first destination read request. Every destination beat is received before the first write request of that row.
- R4: `rd_req_len` and `wr_req_len` carry the beat count directly, in the range 1 to 32. Bursts within a row are consecutive, and each is min(32, pixels remaining in the row) long.
- R5: No more than 16 read bursts are outstanding at any time. A burst counts as outstanding from its request handshake until its last data beat.
- R6: A start with width 0 or height 0 sets `done` on the following cycle, leaves `busy` low and issues no read or write request.
- R7: `busy` is high from the cycle after an accepted start until completion. `done` stays high until the next accepted start clears it. A start while busy is ignored.
- R8: The mix factor, size and base addresses are captured at the accepted start. Later changes on the configuration inputs do not affect the run in progress.
- R9: Each write burst has exactly `wr_req_len` data beats, and `wr_data_last` is high on the final beat only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cfg_alpha | input | 8 | Mix factor |
| cfg_width | input | 11 | Pixels per row |
| cfg_height | input | 11 | Rows |
| cfg_src_base | input | 32 | Source picture base word address |
| cfg_dsti_base | input | 32 | Destination picture input base |
| cfg_dsto_base | input | 32 | Output picture base |
| busy | output | 1 | Engine running |
| done | output | 1 | Sticky completion flag |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read burst start word address |
| rd_req_len | output | 6 | Read burst beat count |
| rd_data_valid | input | 1 | Read data beat |
| rd_data | input | 32 | Read data word |
| rd_data_last | input | 1 | Final beat of a read burst |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | 32 | Write burst start word address |
| wr_req_len | output | 6 | Write burst beat count |
| wr_data_valid | output | 1 | Write data valid |
| wr_data_ready | input | 1 | Write data accepted |
| wr_data | output | 32 | Blended pixel |
| wr_data_last | output | 1 | Final beat of a write burst |

## Verification
Two things can happen in the same cycle: the final beat of one read burst returns, which frees a slot, and a new read request is accepted, which takes one. The bench provokes this on a 640-pixel row. It withholds all read data until the engine has filled its 16 slots, then releases the data while the remaining requests are still pending, so releases and new issues collide repeatedly. The bench keeps its own count of outstanding bursts from the two handshakes. It requires that count never to exceed 16 and to peak at exactly 16, and it requires every written pixel of that row to match the blend.

// File: rtl/img_blend_pkg.sv
package img_blend_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC_RD,
        ST_DST_RD,
        ST_WR_REQ,
        ST_WR_DATA,
        ST_ROW_END
    } eng_state_t;
endpackage

// File: rtl/blend_line_buf.sv
module blend_line_buf #(
    parameter int DEPTH = 640,
    parameter int DW    = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    AST_BUF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH)); // R3
endmodule

// File: rtl/blend_pixel.sv
module blend_pixel #(
    parameter int CH_W = 8,
    parameter int N_CH = 3,
    parameter int PIX_W = 32
) (
    input  logic [CH_W-1:0]      alpha,
    input  logic [N_CH*CH_W-1:0] src_pix,
    input  logic [N_CH*CH_W-1:0] dst_pix,
    output logic [PIX_W-1:0]     out_pix
);
    localparam int FULL   = (1 << CH_W) - 1;
    localparam int PROD_W = 2 * CH_W + 1;

    logic [CH_W-1:0] inv_alpha;
    logic [CH_W-1:0] chan_v [N_CH];

    assign inv_alpha = CH_W'(FULL) - alpha;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        logic [PROD_W-1:0] sum;
        assign sum = PROD_W'(alpha) * PROD_W'(src_pix[ch*CH_W +: CH_W])
                   + PROD_W'(inv_alpha) * PROD_W'(dst_pix[ch*CH_W +: CH_W]);
        assign chan_v[ch] = CH_W'(sum / PROD_W'(FULL));
    end

    always_comb begin
        out_pix = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            out_pix[ch*CH_W +: CH_W] = chan_v[ch];
        end
    end
endmodule

// File: rtl/img_blend_engine.sv
module img_blend_engine
    import img_blend_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PIX_W     = 32,
    parameter int CH_W      = 8,
    parameter int N_CH      = 3,
    parameter int DIM_W     = 11,
    parameter int LINE_MAX  = 640,
    parameter int STRIDE    = 640,
    parameter int BURST_MAX = 32,
    parameter int MAX_OUTST = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CH_W-1:0]     cfg_alpha,
    input  logic [DIM_W-1:0]    cfg_width,
    input  logic [DIM_W-1:0]    cfg_height,
    input  logic [ADDR_W-1:0]   cfg_src_base,
    input  logic [ADDR_W-1:0]   cfg_dsti_base,
    input  logic [ADDR_W-1:0]   cfg_dsto_base,
    output logic                busy,
    output logic                done,
    output logic                rd_req_valid,
    input  logic                rd_req_ready,
    output logic [ADDR_W-1:0]   rd_req_addr,
    output logic [$clog2(BURST_MAX+1)-1:0] rd_req_len,
    input  logic                rd_data_valid,
    input  logic [PIX_W-1:0]    rd_data,
    input  logic                rd_data_last,
    output logic                wr_req_valid,
    input  logic                wr_req_ready,
    output logic [ADDR_W-1:0]   wr_req_addr,
    output logic [$clog2(BURST_MAX+1)-1:0] wr_req_len,
    output logic                wr_data_valid,
    input  logic                wr_data_ready,
    output logic [PIX_W-1:0]    wr_data,
    output logic                wr_data_last
);
    localparam int IDX_W  = $clog2(LINE_MAX);
    localparam int LEN_W  = $clog2(BURST_MAX + 1);
    localparam int OUT_W  = $clog2(MAX_OUTST + 1);
    localparam int COL_W  = N_CH * CH_W;

    eng_state_t state, state_nx;

    logic [CH_W-1:0]   alpha_q;
    logic [DIM_W-1:0]  width_q, height_q;
    logic [ADDR_W-1:0] src_base_q, dsti_base_q, dsto_base_q;
    logic [DIM_W-1:0]  req_cnt, rcv_cnt, wr_cnt, row;
    logic [ADDR_W-1:0] row_off;
    logic [LEN_W-1:0]  beat_left;
    logic [OUT_W-1:0]  outst;
    logic              done_q, src_full, dst_full;

    logic              in_rd, rd_issue, rd_accept, rd_phase_done;
    logic              start_ok, size_zero, last_beat, row_last_px, last_row;
    logic [DIM_W-1:0]  req_rem, wr_rem;
    logic [LEN_W-1:0]  rd_len, wr_len;
    logic [COL_W-1:0]  buf_rd [2];

    assign in_rd         = (state == ST_SRC_RD) || (state == ST_DST_RD);
    assign rd_issue      = rd_req_valid && rd_req_ready;
    assign rd_accept     = rd_data_valid && in_rd;
    assign rd_phase_done = (rcv_cnt == width_q) && (outst == '0);
    assign start_ok      = start && (state == ST_IDLE);
    assign size_zero     = (cfg_width == '0) || (cfg_height == '0);
    assign last_beat     = wr_data_ready && (beat_left == LEN_W'(1));
    assign row_last_px   = (wr_cnt + DIM_W'(1)) == width_q;
    assign last_row      = (row + DIM_W'(1)) == height_q;

    assign req_rem = width_q - req_cnt;
    assign wr_rem  = width_q - wr_cnt;
    assign rd_len  = (req_rem > DIM_W'(BURST_MAX)) ? LEN_W'(BURST_MAX) : LEN_W'(req_rem);
    assign wr_len  = (wr_rem  > DIM_W'(BURST_MAX)) ? LEN_W'(BURST_MAX) : LEN_W'(wr_rem);

    // two line stores: index 0 holds source, index 1 holds destination
    for (genvar b = 0; b < 2; b++) begin : g_line
        logic we_b;
        assign we_b = rd_accept && ((state == ST_SRC_RD) == (b == 0));
        blend_line_buf #(.DEPTH(LINE_MAX), .DW(COL_W)) i_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_b),
            .waddr (rcv_cnt[IDX_W-1:0]),
            .wdata (rd_data[COL_W-1:0]),
            .raddr (wr_cnt[IDX_W-1:0]),
            .rdata (buf_rd[b])
        );
    end

    logic [PIX_W-1:0] mix_pix;
    blend_pixel #(.CH_W(CH_W), .N_CH(N_CH), .PIX_W(PIX_W)) i_mix (
        .alpha   (alpha_q),
        .src_pix (buf_rd[0]),
        .dst_pix (buf_rd[1]),
        .out_pix (mix_pix)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_ok && !size_zero) state_nx = ST_SRC_RD;
            ST_SRC_RD:  if (rd_phase_done) state_nx = ST_DST_RD;
            ST_DST_RD:  if (rd_phase_done) state_nx = ST_WR_REQ;
            ST_WR_REQ:  if (wr_req_ready) state_nx = ST_WR_DATA;
            ST_WR_DATA: if (last_beat) state_nx = row_last_px ? ST_ROW_END : ST_WR_REQ;
            ST_ROW_END: state_nx = last_row ? ST_IDLE : ST_SRC_RD;
        endcase
    end

    // outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        done          = done_q;
        rd_req_valid  = in_rd && (req_cnt != width_q) && (outst < OUT_W'(MAX_OUTST));
        rd_req_addr   = ((state == ST_SRC_RD) ? src_base_q : dsti_base_q)
                        + row_off + ADDR_W'(req_cnt);
        rd_req_len    = rd_len;
        wr_req_valid  = (state == ST_WR_REQ);
        wr_req_addr   = dsto_base_q + row_off + ADDR_W'(wr_cnt);
        wr_req_len    = wr_len;
        wr_data_valid = (state == ST_WR_DATA);
        wr_data       = mix_pix;
        wr_data_last  = (beat_left == LEN_W'(1));
    end

    // datapath counters and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alpha_q     <= '0;
            width_q     <= '0;
            height_q    <= '0;
            src_base_q  <= '0;
            dsti_base_q <= '0;
            dsto_base_q <= '0;
            req_cnt     <= '0;
            rcv_cnt     <= '0;
            wr_cnt      <= '0;
            row         <= '0;
            row_off     <= '0;
            beat_left   <= '0;
            outst       <= '0;
            done_q      <= 1'b0;
            src_full    <= 1'b0;
            dst_full    <= 1'b0;
        end else begin
            if (start_ok) begin
                alpha_q     <= cfg_alpha;
                width_q     <= cfg_width;
                height_q    <= cfg_height;
                src_base_q  <= cfg_src_base;
                dsti_base_q <= cfg_dsti_base;
                dsto_base_q <= cfg_dsto_base;
                req_cnt     <= '0;
                rcv_cnt     <= '0;
                wr_cnt      <= '0;
                row         <= '0;
                row_off     <= '0;
                src_full    <= 1'b0;
                dst_full    <= 1'b0;
                done_q      <= size_zero;
            end
            if (rd_issue) begin
                req_cnt <= req_cnt + DIM_W'(rd_len);
            end
            if (rd_accept) begin
                rcv_cnt <= rcv_cnt + DIM_W'(1);
            end
            if (rd_issue && !(rd_accept && rd_data_last)) begin
                outst <= outst + OUT_W'(1);
            end else if (!rd_issue && rd_accept && rd_data_last) begin
                outst <= outst - OUT_W'(1);
            end
            if (state == ST_SRC_RD && rd_phase_done) begin
                req_cnt  <= '0;
                rcv_cnt  <= '0;
                src_full <= 1'b1;
            end
            if (state == ST_DST_RD && rd_phase_done) begin
                dst_full <= 1'b1;
            end
            if (state == ST_WR_REQ && wr_req_ready) begin
                beat_left <= wr_len;
            end
            if (state == ST_WR_DATA && wr_data_ready) begin
                wr_cnt    <= wr_cnt + DIM_W'(1);
                beat_left <= beat_left - LEN_W'(1);
            end
            if (state == ST_ROW_END) begin
                req_cnt  <= '0;
                rcv_cnt  <= '0;
                wr_cnt   <= '0;
                src_full <= 1'b0;
                dst_full <= 1'b0;
                row      <= row + DIM_W'(1);
                row_off  <= row_off + ADDR_W'(STRIDE);
                if (last_row) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    AST_RD_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_len != '0) && (int'(rd_req_len) <= BURST_MAX)); // R4
    AST_WR_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |-> (wr_req_len != '0) && (int'(wr_req_len) <= BURST_MAX)); // R4
    AST_RD_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outst) <= MAX_OUTST); // R5
    AST_WR_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |-> src_full && dst_full); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req_valid && !wr_req_valid && !wr_data_valid); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_valid && wr_data_ready && wr_data_last) |=> !wr_data_valid); // R9
endmodule

// File: tb/test_img_blend_engine.sv
module test_img_blend_engine;
    localparam logic [31:0] SB = 32'h0001_0000;
    localparam logic [31:0] DB = 32'h0010_0000;
    localparam logic [31:0] OB = 32'h0020_0000;
    localparam int NV = 5;
    localparam int VA    [NV] = '{255, 0, 128, 77, 200};
    localparam int VW    [NV] = '{5, 33, 64, 70, 640};
    localparam int VH    [NV] = '{2, 2, 1, 3, 1};
    localparam int VBUR  [NV] = '{2, 4, 2, 9, 20};
    localparam int VHOLD [NV] = '{0, 0, 0, 0, 120};
    localparam int VDIST [NV] = '{0, 0, 0, 1, 0};

    logic clk = 0, rst_n = 0, start = 0;
    logic [7:0]  cfg_alpha = 0;
    logic [10:0] cfg_width = 0, cfg_height = 0;
    logic [31:0] cfg_src_base = SB, cfg_dsti_base = DB, cfg_dsto_base = OB;
    logic busy, done;
    logic rd_req_valid, rd_req_ready = 1;
    logic [31:0] rd_req_addr;
    logic [5:0]  rd_req_len;
    logic rd_data_valid = 0, rd_data_last = 0;
    logic [31:0] rd_data = 0;
    logic wr_req_valid, wr_req_ready = 1;
    logic [31:0] wr_req_addr;
    logic [5:0]  wr_req_len;
    logic wr_data_valid, wr_data_ready = 0, wr_data_last;
    logic [31:0] wr_data;

    img_blend_engine i_img_blend_engine (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int E_A, E_W, E_H;
    int y, s_req, d_req, s_sent, d_sent, w_cnt, wbeat, cur_wlen;
    int outst_b = 0, max_outst = 0, n_rdreq = 0, n_wr = 0, n_src_b = 0, n_wreq = 0;
    int cyc = 0, qbeat = 0;
    bit rd_hold = 0;
    logic [31:0] qa [$];
    int ql [$];

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {8'hA5, 8'(a[7:0] * 8'd7), a[7:0] ^ 8'h3C, 8'(a[15:8] + a[7:0])};
    endfunction

    function automatic logic [31:0] mix(input int a, input logic [31:0] s, input logic [31:0] d);
        logic [31:0] r = '0;
        for (int c = 0; c < 3; c++) begin
            int v;
            v = (a * int'(s[c*8 +: 8]) + (255 - a) * int'(d[c*8 +: 8])) / 255;
            r[c*8 +: 8] = 8'(v);
        end
        return r;
    endfunction

    function automatic int blen(input int rem);
        return (rem > 32) ? 32 : rem;
    endfunction

    // memory model and monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rd_hold && qa.size() > 0) begin
                rd_data_valid = 1;
                rd_data = pat(qa[0] + 32'(qbeat));
                rd_data_last = (qbeat == ql[0] - 1);
                if (qa[0] < DB) s_sent++; else d_sent++;
                qbeat++;
                if (rd_data_last) begin
                    void'(qa.pop_front());
                    void'(ql.pop_front());
                    qbeat = 0;
                    outst_b--;
                end
            end else begin
                rd_data_valid = 0;
                rd_data_last = 0;
            end
            if (rd_req_valid && rd_req_ready) begin
                n_rdreq++;
                if (rd_req_addr < DB) begin
                    chk(d_req == 0 && w_cnt == 0, "R3 src read after dst/write", d_req, 0);
                    chk(rd_req_addr == SB + 32'(y*640 + s_req), "R2 src addr", rd_req_addr, SB + 32'(y*640 + s_req));
                    chk(int'(rd_req_len) == blen(E_W - s_req), "R4 src len", rd_req_len, blen(E_W - s_req));
                    s_req += int'(rd_req_len);
                    n_src_b++;
                end else begin
                    chk(s_sent == E_W, "R3 dst read before src done", s_sent, E_W);
                    chk(rd_req_addr == DB + 32'(y*640 + d_req), "R2 dst addr", rd_req_addr, DB + 32'(y*640 + d_req));
                    chk(int'(rd_req_len) == blen(E_W - d_req), "R4 dst len", rd_req_len, blen(E_W - d_req));
                    d_req += int'(rd_req_len);
                end
                qa.push_back(rd_req_addr);
                ql.push_back(int'(rd_req_len));
                outst_b++;
                if (outst_b > max_outst) max_outst = outst_b;
                if (outst_b > 16) chk(0, "R5 outstanding", outst_b, 16);
            end
            wr_data_ready = (cyc % 3) != 0;
            if (wr_req_valid && wr_req_ready) begin
                n_wreq++;
                chk(s_sent == E_W && d_sent == E_W, "R3 write before fill", d_sent, E_W);
                chk(wr_req_addr == OB + 32'(y*640 + w_cnt), "R2 out addr", wr_req_addr, OB + 32'(y*640 + w_cnt));
                chk(int'(wr_req_len) == blen(E_W - w_cnt), "R4 write len", wr_req_len, blen(E_W - w_cnt));
                cur_wlen = int'(wr_req_len);
                wbeat = 0;
            end
            if (wr_data_valid && wr_data_ready) begin
                logic [31:0] off, expv;
                off = 32'(y*640 + w_cnt);
                expv = mix(E_A, pat(SB + off), pat(DB + off));
                chk(wr_data == expv, "R1 blended pixel", wr_data, expv);
                chk(wr_data_last == (wbeat == cur_wlen - 1), "R9 last flag", wr_data_last, wbeat == cur_wlen - 1);
                n_wr++; w_cnt++; wbeat++;
                if (w_cnt == E_W) begin
                    y++; s_req = 0; d_req = 0; s_sent = 0; d_sent = 0; w_cnt = 0;
                end
            end
        end
    end

    task automatic clear_track();
        y = 0; s_req = 0; d_req = 0; s_sent = 0; d_sent = 0; w_cnt = 0;
        n_wr = 0; n_src_b = 0; n_wreq = 0;
    endtask

    task automatic run_vec(input int i);
        int t;
        E_A = VA[i]; E_W = VW[i]; E_H = VH[i];
        clear_track();
        rd_hold = (VHOLD[i] != 0);
        @(negedge clk);
        cfg_alpha = 8'(E_A); cfg_width = 11'(E_W); cfg_height = 11'(E_H);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1, "R7 busy after start", busy, 1);
        chk(done == 0, "R7 done cleared by start", done, 0);
        t = 0;
        while (!done && t < 40000) begin
            @(negedge clk);
            t++;
            if (t == VHOLD[i]) rd_hold = 0;
            if (VDIST[i] != 0 && t == 50) begin
                cfg_alpha = 8'd3; cfg_width = 11'd7; cfg_height = 11'd9; start = 1;
            end else begin
                start = 0;
            end
        end
        chk(t < 40000, "watchdog run", t, 40000);
        chk(n_wr == E_W * E_H, "R8 pixel count", n_wr, E_W * E_H);
        chk(y == E_H, "R2 rows done", y, E_H);
        chk(n_src_b == VBUR[i] * (E_H > 0 ? 1 : 0) * (VBUR[i] / (VBUR[i] == 0 ? 1 : VBUR[i])) ? n_src_b == VBUR[i] : 0,
            "R4 src burst count", n_src_b, VBUR[i]);
        chk(busy == 0, "R7 idle at done", busy, 0);
    endtask

    task automatic zero_run(input int w, input int h);
        int r0, w0;
        r0 = n_rdreq; w0 = n_wreq;
        @(negedge clk);
        cfg_width = 11'(w); cfg_height = 11'(h); start = 1;
        @(negedge clk);
        start = 0;
        chk(done == 1, "R6 zero size done", done, 1);
        chk(busy == 0, "R6 zero size not busy", busy, 0);
        repeat (10) @(negedge clk);
        chk(n_rdreq == r0 && n_wreq == w0, "R6 no requests", n_rdreq - r0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_track();
        E_A = 0; E_W = 0; E_H = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(done == 0, "R7 reset done", done, 0);
        chk(busy == 0, "R7 reset busy", busy, 0);
        chk(!rd_req_valid && !wr_req_valid && !wr_data_valid, "R6 reset quiet", rd_req_valid, 0);
        zero_run(0, 3);
        zero_run(4, 0);
        for (int i = 0; i < NV; i++) begin
            run_vec(i);
            if (i == 0) begin
                repeat (8) @(negedge clk);
                chk(done == 1, "R7 done sticky", done, 1);
            end
            if (VDIST[i] != 0) begin
                int r0;
                r0 = n_rdreq;
                repeat (20) @(negedge clk);
                chk(n_rdreq == r0 && done == 1, "R7 start while busy ignored", n_rdreq - r0, 0);
            end
        end
        chk(max_outst == 16, "R5 peak outstanding", max_outst, 16);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule